// File: doc/BRIEF.md
# Encoded-Timeout Watchdog Timer

This block is a one-shot watchdog that software programs through a single 8-bit register. The register holds a 5-bit multiplier, a 2-bit resolution code and a steering bit. The timeout is counted in ticks of an external 16 Hz enable strobe, so one tick is one sixteenth of a second. Software keeps the system alive by touching the register. A write loads a new setting. A read restarts the count with the stored setting.

When the count runs out, the block sets a sticky flag that software can read. The steering bit then chooses the action. With the bit clear, the block raises a one-cycle interrupt pulse. With the bit set, it raises a one-cycle reset request, clears the watchdog register, and clears a century bit kept in a neighbouring register.

After either kind of expiry the watchdog stays idle until software touches the register again. Reads return data in the same cycle through a combinational mux. Registers are selected by address on a byte-wide bus.

Top module: `wdog_timer`

## Requirements
- R1: After reset, irqPulse and resetReq are low, and reads of the flag register (0x1FF0), the watchdog register (0x1FF7) and the century register (0x1FFC) all return 0x00.
- R2: In the watchdog register, bits 6:2 are the multiplier M and bits 1:0 are the resolution code R. The timeout is M × 4^R ticks. Expiry takes effect on exactly that tick after the last kick. Cycles in which tick16 is low do not advance the count.
- R3: Any register value whose multiplier field is zero, including 0x00, disables the watchdog, and no expiry occurs however many ticks arrive.
- R4: A write to the watchdog register stores the value, clears the flag and restarts the count from the new timeout.
- R5: A read of the watchdog register returns the stored value and restarts the count from the stored setting.
- R6: On expiry, bit 7 of the flag register (0x1FF0) reads 1 and stays set until the next watchdog write. Bits 6:0 of that register read 0, and writes to it have no effect.
- R7: With bit 7 of the watchdog register clear at expiry, irqPulse is high for exactly one cycle, the register keeps its value, and no further expiry occurs until the next kick.
- R8: With bit 7 set at expiry, resetReq is high for exactly one cycle, the watchdog register reads 0x00 and bit 6 of the century register reads 0. A later read kick leaves the watchdog disabled.
- R9: The century register stores only bit 6 of a written value, and all its other bits read 0.
- R10: A kick in the same cycle as the final tick takes priority: no expiry happens in that cycle, and the count restarts.
- R11: irqPulse and resetReq are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle enable at 16 Hz |
| busAddr | input | 13 | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (kicks on the watchdog address) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for busAddr, same cycle |
| irqPulse | output | 1 | One-cycle interrupt on steered expiry |
| resetReq | output | 1 | One-cycle system reset request on steered expiry |

## Verification
The timeout computation is exercised with random multipliers and every resolution code. The ticks are spaced by random idle gaps, so an off-by-one tick count or counting in clocks shows up as a pulse on the wrong tick. Directed cases cover the following:
- the shortest timeout (one tick) and the longest (1984 ticks), which separate shift and width errors;
- a zero multiplier paired with a nonzero resolution code, which separates a disable decision made on the multiplier from one made on the whole byte;
- both settings of the steering bit, which separate the interrupt path from the reset path and its register clears;
- a read kick and a rewrite placed mid-count and on the final tick, which expose a missing reload or the wrong priority between a kick and expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W     = 8;
  localparam int MULT_W    = 5;
  localparam int RES_W     = 2;
  localparam int MULT_LSB  = RES_W;
  localparam int STEER_BIT = REG_W - 1;
  localparam int MAX_SHIFT = 2 * ((1 << RES_W) - 1);
  localparam int CNT_W     = MULT_W + MAX_SHIFT;

  typedef struct packed {
    logic loadNew;    // write to watchdog register
    logic reloadOld;  // read kick, reuse stored setting
    logic centWr;     // write to century register
    logic decr;       // count one tick
    logic fireIrq;    // expiry, interrupt steered
    logic fireRst;    // expiry, reset steered
  } wdCmd_t;

  function automatic logic [CNT_W-1:0] ticksFor(input logic [REG_W-1:0] v);
    logic [CNT_W-1:0] m;
    m = CNT_W'(v[MULT_LSB +: MULT_W]);
    return m << (2 * v[RES_W-1:0]);
  endfunction
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] WD_ADDR = 13'h1FF7,
  parameter logic [ADDR_W-1:0] CENT_ADDR = 13'h1FFC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              armed,
  input  logic              cntLast,
  input  logic              steerRst,
  output wdCmd_t            cmd,
  output logic              irqPulse,
  output logic              resetReq
);
  logic hitWd, kickWr, kickRd, step;

  always_comb begin
    hitWd  = (busAddr == WD_ADDR);
    kickWr = wrEn & hitWd;
    kickRd = rdEn & hitWd & ~kickWr;
    // a kick in the same cycle as a tick wins over counting and expiry
    step   = tick16 & armed & ~kickWr & ~kickRd;
    cmd.loadNew   = kickWr;
    cmd.reloadOld = kickRd;
    cmd.centWr    = wrEn & (busAddr == CENT_ADDR);
    cmd.decr      = step & ~cntLast;
    cmd.fireIrq   = step & cntLast & ~steerRst;
    cmd.fireRst   = step & cntLast & steerRst;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPulse <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      irqPulse <= cmd.fireIrq;
      resetReq <= cmd.fireRst;
    end
  end
endmodule

// File: rtl/wdog_dpath.sv
module wdog_dpath
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 13'h1FF0,
  parameter logic [ADDR_W-1:0] WD_ADDR = 13'h1FF7,
  parameter logic [ADDR_W-1:0] CENT_ADDR = 13'h1FFC,
  parameter int CENT_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdCmd_t            cmd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic              armed,
  output logic              cntLast,
  output logic              steerRst,
  output logic              wdFlag,
  output logic [REG_W-1:0]  wdValue
);
  logic [REG_W-1:0] wdReg;
  logic [CNT_W-1:0] count;
  logic             flagQ, centQ, armedQ;
  logic [CNT_W-1:0] newTicks, oldTicks;

  assign newTicks = ticksFor(wrData);
  assign oldTicks = ticksFor(wdReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdReg  <= '0;
      count  <= '0;
      flagQ  <= 1'b0;
      centQ  <= 1'b0;
      armedQ <= 1'b0;
    end else begin
      if (cmd.centWr) centQ <= wrData[CENT_BIT];
      if (cmd.loadNew) begin
        wdReg  <= wrData;
        flagQ  <= 1'b0;
        count  <= newTicks;
        armedQ <= (newTicks != '0);
      end else if (cmd.reloadOld) begin
        count  <= oldTicks;
        armedQ <= (oldTicks != '0);
      end else if (cmd.fireIrq || cmd.fireRst) begin
        flagQ  <= 1'b1;
        armedQ <= 1'b0;
        if (cmd.fireRst) begin
          wdReg <= '0;
          centQ <= 1'b0;
        end
      end else if (cmd.decr) begin
        count <= count - 1'b1;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (busAddr == FLAG_ADDR)      rdData[REG_W-1] = flagQ;
    else if (busAddr == WD_ADDR)   rdData = wdReg;
    else if (busAddr == CENT_ADDR) rdData[CENT_BIT] = centQ;
  end

  assign armed    = armedQ;
  assign cntLast  = (count == CNT_W'(1));
  assign steerRst = wdReg[STEER_BIT];
  assign wdFlag   = flagQ;
  assign wdValue  = wdReg;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 13'h1FF0,
  parameter logic [ADDR_W-1:0] WD_ADDR = 13'h1FF7,
  parameter logic [ADDR_W-1:0] CENT_ADDR = 13'h1FFC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              irqPulse,
  output logic              resetReq
);
  wdCmd_t           cmd;
  logic             armed, cntLast, steerRst, wdFlag;
  logic [REG_W-1:0] wdValue;

  wdog_ctrl #(.ADDR_W(ADDR_W), .WD_ADDR(WD_ADDR), .CENT_ADDR(CENT_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick16(tick16), .busAddr(busAddr),
    .wrEn(wrEn), .rdEn(rdEn), .armed(armed), .cntLast(cntLast),
    .steerRst(steerRst), .cmd(cmd), .irqPulse(irqPulse), .resetReq(resetReq)
  );

  wdog_dpath #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .WD_ADDR(WD_ADDR),
               .CENT_ADDR(CENT_ADDR)) u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .busAddr(busAddr), .wrData(wrData),
    .rdData(rdData), .armed(armed), .cntLast(cntLast), .steerRst(steerRst),
    .wdFlag(wdFlag), .wdValue(wdValue)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] WD_ADDR = 13'h1FF7
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick16,
  input logic [ADDR_W-1:0] busAddr,
  input logic              wrEn,
  input logic              rdEn,
  input logic              irqPulse,
  input logic              resetReq,
  input logic              wdFlag,
  input logic [7:0]        wdValue
);
  // R11
  excl_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irqPulse, resetReq}));

  // R6
  flag_on_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse || resetReq) |-> wdFlag);

  // R4
  wr_clears_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busAddr == WD_ADDR) |=> !wdFlag);

  // R8
  rst_clears_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (wdValue == 8'h00));

  // R7
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R10
  kick_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick16 && (wrEn || rdEn) && busAddr == WD_ADDR) |=> (!irqPulse && !resetReq));
endmodule

bind wdog_timer wdog_chk #(.ADDR_W(ADDR_W), .WD_ADDR(WD_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .tick16(tick16), .busAddr(busAddr), .wrEn(wrEn),
  .rdEn(rdEn), .irqPulse(irqPulse), .resetReq(resetReq), .wdFlag(wdFlag),
  .wdValue(wdValue)
);

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
  localparam logic [12:0] A_FLAG = 13'h1FF0;
  localparam logic [12:0] A_WD   = 13'h1FF7;
  localparam logic [12:0] A_CENT = 13'h1FFC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b0;
  logic [12:0] busAddr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic irqPulse, resetReq;

  int nChk = 0, nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wdog_timer u0 (
    .clk(clk), .rstN(rstN), .tick16(tick16), .busAddr(busAddr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .irqPulse(irqPulse),
    .resetReq(resetReq)
  );

  function automatic int expTicks(input logic [7:0] v);
    return int'(v[6:2]) << (2 * int'(v[1:0]));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // n ticks with random gaps; reports the tick index of the first pulse of each kind
  task automatic runTicks(input int n, output int firstIrq, output int firstRst,
                          output int nIrq, output int nRst);
    firstIrq = 0; firstRst = 0; nIrq = 0; nRst = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
      if (irqPulse) begin nIrq++; if (firstIrq == 0) firstIrq = i; end
      if (resetReq) begin nRst++; if (firstRst == 0) firstRst = i; end
      for (int g = 0; g < int'($urandom_range(0, 2)); g++) begin
        @(negedge clk);
        if (irqPulse) nIrq++;
        if (resetReq) nRst++;
      end
    end
  endtask

  initial begin
    #800000;
    nChk++; nFail++;
    $display("FAIL watchdog: actual=0x0 expected=0x1");
    finish();
  end

  initial begin
    logic [7:0] d, v;
    int fi, fr, ni, nr, t;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!irqPulse && !resetReq, "R1 outputs", {irqPulse, resetReq}, 0);
    rd(A_FLAG, d); check(d == 8'h00, "R1 flag", d, 0);
    rd(A_WD, d);   check(d == 8'h00, "R1 wdreg", d, 0);
    rd(A_CENT, d); check(d == 8'h00, "R1 cent", d, 0);

    // R9 century register stores bit 6 only
    wr(A_CENT, 8'hFF); rd(A_CENT, d); check(d == 8'h40, "R9 cent ff", d, 8'h40);
    wr(A_CENT, 8'hBF); rd(A_CENT, d); check(d == 8'h00, "R9 cent bf", d, 0);

    // R2 shortest timeout: one tick
    wr(A_WD, 8'h04);
    runTicks(3, fi, fr, ni, nr);
    check(fi == 1 && ni == 1 && nr == 0, "R2 one tick", fi, 1);
    rd(A_FLAG, d); check(d == 8'h80, "R6 flag set", d, 8'h80);
    wr(A_FLAG, 8'h00); rd(A_FLAG, d); check(d == 8'h80, "R6 flag read-only", d, 8'h80);
    rd(A_WD, d); check(d == 8'h04, "R7 reg kept", d, 8'h04);

    // R7 one-shot: no further expiry without kick (read above kicked, so re-expire once)
    runTicks(4, fi, fr, ni, nr);
    check(ni == 1 && fi == 1, "R5 read kick reloads", ni, 1);
    runTicks(4, fi, fr, ni, nr);
    check(ni == 0 && nr == 0, "R7 no repeat", ni, 0);

    // R3 zero multiplier with nonzero resolution, and zero value
    wr(A_WD, 8'h03);
    runTicks(40, fi, fr, ni, nr);
    check(ni == 0 && nr == 0, "R3 mult zero res 3", ni + nr, 0);
    wr(A_WD, 8'h00);
    runTicks(10, fi, fr, ni, nr);
    check(ni == 0 && nr == 0, "R3 zero value", ni + nr, 0);

    // R4 rewrite mid-count restarts and clears flag
    wr(A_WD, 8'h04); runTicks(1, fi, fr, ni, nr);
    wr(A_WD, 8'h14);  // M=5 R=0
    rd(A_FLAG, d); check(d == 8'h00, "R4 flag cleared", d, 0);
    runTicks(3, fi, fr, ni, nr);
    wr(A_WD, 8'h14);
    runTicks(7, fi, fr, ni, nr);
    check(fi == 5 && ni == 1, "R4 restart", fi, 5);

    // R5 read kick mid-count
    wr(A_WD, 8'h0D);  // M=3 R=1 -> 12
    runTicks(10, fi, fr, ni, nr);
    rd(A_WD, d); check(d == 8'h0D, "R5 read value", d, 8'h0D);
    runTicks(14, fi, fr, ni, nr);
    check(fi == 12 && ni == 1, "R5 read restart", fi, 12);

    // R10 kick on the final tick wins
    wr(A_WD, 8'h0C);  // 3 ticks
    runTicks(2, fi, fr, ni, nr);
    @(negedge clk);
    busAddr = A_WD; rdEn = 1'b1; tick16 = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; tick16 = 1'b0;
    check(!irqPulse && !resetReq, "R10 no fire", irqPulse, 0);
    runTicks(4, fi, fr, ni, nr);
    check(fi == 3 && ni == 1, "R10 restarted", fi, 3);

    // R8 reset-steered expiry
    wr(A_CENT, 8'h40);
    wr(A_WD, 8'h89);  // M=2 R=1 -> 8, steer reset
    runTicks(10, fi, fr, ni, nr);
    check(fr == 8 && nr == 1 && ni == 0, "R8 reset pulse", fr, 8);
    rd(A_WD, d);   check(d == 8'h00, "R8 reg cleared", d, 0);
    rd(A_CENT, d); check(d == 8'h00, "R8 cent cleared", d, 0);
    rd(A_FLAG, d); check(d == 8'h80, "R8 flag", d, 8'h80);
    runTicks(10, fi, fr, ni, nr);
    check(ni == 0 && nr == 0, "R8 stays disabled", ni + nr, 0);

    // R2 longest timeout
    wr(A_WD, 8'h7F);
    runTicks(1986, fi, fr, ni, nr);
    check(fi == 1984 && ni == 1, "R2 max timeout", fi, 1984);

    // R2/R7/R8 random settings
    for (int k = 0; k < 24; k++) begin
      v = {1'($urandom_range(0, 1)), 5'($urandom_range(0, 7)), 2'($urandom_range(0, 2))};
      t = expTicks(v);
      wr(A_WD, v);
      runTicks(t + 3, fi, fr, ni, nr);
      if (t == 0)
        check(ni == 0 && nr == 0, "R3 random zero", ni + nr, 0);
      else if (v[7])
        check(fr == t && nr == 1 && ni == 0, "R8 random", fr, t);
      else
        check(fi == t && ni == 1 && nr == 0, "R2 random", fi, t);
      check(!(irqPulse && resetReq), "R11 exclusive", {irqPulse, resetReq}, 0);
    end

    finish();
  end
endmodule